// File: doc/BRIEF.md
# Unaligned Access Byte-Enable Splitter

This block takes one memory or I/O request from a processor-side port and turns it into the bus cycles needed on a physical bus that is four bytes wide. A request gives a byte address, a size of one, two or four bytes, a direction, and right-justified write data. If all requested bytes fall in one physical word, the block issues one bus cycle. If the bytes run past the end of a word, it issues two cycles. The cycle for the lower word always goes first, and the cycle for the next word address follows.

Each bus cycle carries a word-aligned address and a four-bit lane enable. Only lanes that hold requested bytes are enabled, because a stray access can corrupt memory on a write or disturb a peripheral even on a read. Write bytes are moved onto the lanes that match their addresses. On a read, the bytes collected from one or two cycles are shifted back into a right-justified result. The block pulses a completion flag once per request and presents the result with that pulse.

Both sides use a valid/ready handshake. The block takes no new request until the last bus cycle of the current one has completed.

Top module: `ua_split`

## Requirements
- R1: While rst_n is low, and in the first cycle after it goes high, req_ready is 1 and bus_valid and done are 0.
- R2: req_size encodes the byte count: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. The first bus cycle has bus_addr equal to req_addr with bits [1:0] cleared. Its bus_be is the low-bit mask of that many ones, shifted left by req_addr[1:0] and cut to 4 bits. Bit j of bus_be enables bits [8j+7:8j] of the data lanes.
- R3: When req_addr[1:0] plus the byte count exceeds 4, a second bus cycle is issued only after the first has completed. Its bus_addr is 4 above the first, and its bus_be holds the mask bits that the shift pushed past lane 3. Otherwise exactly one bus cycle is issued.
- R4: No lane is enabled unless it holds a requested byte. Over all cycles of one request, the number of enabled lanes equals the byte count.
- R5: Byte k of req_wdata (bits [8k+7:8k]) is driven on lane (req_addr[1:0]+k) mod 4 of the cycle whose word holds address req_addr+k. bus_write equals req_write for every cycle of the request.
- R6: While bus_valid is 1 and bus_ready is 0, bus_valid stays 1 and bus_addr, bus_be, bus_write and bus_wdata hold their values in the next cycle.
- R7: For a read, byte k of done_rdata is the byte returned on the lane that carried address req_addr+k, for k below the byte count. The remaining high bytes are 0. Data on lanes that were not enabled does not affect the result.
- R8: done is high for exactly one cycle, the cycle after the final bus handshake of a request. done_rdata is valid in that cycle and is 0 for a write.
- R9: req_ready is 0 from the acceptance edge until the final bus handshake. A request held valid meanwhile is not accepted, so no extra bus cycle and no extra done pulse occur.
- R10: The second cycle's word address wraps modulo 2^ADDR_W, so a request at the top of the address space continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Right-justified write data |
| bus_valid | output | 1 | Bus cycle present |
| bus_ready | input | 1 | Bus cycle completes on this edge |
| bus_addr | output | ADDR_W | Word-aligned bus address |
| bus_be | output | 4 | Per-lane byte enables |
| bus_write | output | 1 | Bus cycle direction |
| bus_wdata | output | 32 | Lane-aligned write data |
| bus_rdata | input | 32 | Lane read data, sampled at the handshake |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | 32 | Right-justified read result, valid with done |

## Verification
Byte reads are run at all four offsets. A mismatch in any of them shows a wrong enable shift, because a single byte can never split. Half-word and word accesses are run at aligned offsets and at offsets that force a split. These separate the overflow mask of the second cycle from the first, and a swapped cycle order or a wrong second address shows up as bad data. The bus returns junk on disabled lanes, so a read that fails to mask or shift lanes returns a visibly wrong value. Split writes are run with a stalled bus and then read back, and one word access wraps from the top of the address space to address 0.

// File: rtl/ua_split.sv
module ua_split #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        bus_be,
  output logic              bus_write,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  output logic              done,
  output logic [31:0]       done_rdata
);

  localparam int LANES = 4;
  localparam int WA_W  = ADDR_W - 2;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_t;

  st_t               st_q;
  logic [WA_W-1:0]   word_q;
  logic [1:0]        off_q;
  logic [LANES-1:0]  smask_q, be_lo_q, be_hi_q;
  logic [31:0]       wd_lo_q, wd_hi_q, rd_lo_q;
  logic              wr_q;

  logic [LANES-1:0]   smask;
  logic [2*LANES-1:0] be_wide;
  logic [63:0]        wd_wide, rd_pair, rd_shift;
  logic [31:0]        rd_res, keep;
  logic               accept, hs, last_cyc;

  assign smask = (req_size == 2'd0) ? 4'b0001 :
                 (req_size == 2'd1) ? 4'b0011 : 4'b1111;
  assign be_wide = {4'b0000, smask} << req_addr[1:0];
  assign wd_wide = {32'h0, req_wdata} << {req_addr[1:0], 3'b000};

  assign req_ready = (st_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign hs        = bus_valid && bus_ready;
  assign last_cyc  = (st_q == S_HI) || (be_hi_q == 4'b0000);

  assign bus_valid = (st_q != S_IDLE);
  assign bus_addr  = {(st_q == S_HI) ? word_q + 1'b1 : word_q, 2'b00};
  assign bus_be    = (st_q == S_HI) ? be_hi_q : be_lo_q;
  assign bus_wdata = (st_q == S_HI) ? wd_hi_q : wd_lo_q;
  assign bus_write = wr_q;

  assign rd_pair  = (st_q == S_HI) ? {bus_rdata, rd_lo_q} : {32'h0, bus_rdata};
  assign rd_shift = rd_pair >> {off_q, 3'b000};
  assign keep     = {{8{smask_q[3]}}, {8{smask_q[2]}}, {8{smask_q[1]}}, {8{smask_q[0]}}};
  assign rd_res   = rd_shift[31:0] & keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      word_q     <= '0;
      off_q      <= '0;
      smask_q    <= '0;
      be_lo_q    <= '0;
      be_hi_q    <= '0;
      wd_lo_q    <= '0;
      wd_hi_q    <= '0;
      rd_lo_q    <= '0;
      wr_q       <= 1'b0;
      done       <= 1'b0;
      done_rdata <= '0;
    end else begin
      done <= hs && last_cyc;
      if (hs && last_cyc)
        done_rdata <= wr_q ? 32'h0 : rd_res;
      case (st_q)
        S_IDLE: if (accept) begin
          st_q    <= S_LO;
          word_q  <= req_addr[ADDR_W-1:2];
          off_q   <= req_addr[1:0];
          smask_q <= smask;
          be_lo_q <= be_wide[3:0];
          be_hi_q <= be_wide[7:4];
          wd_lo_q <= wd_wide[31:0];
          wd_hi_q <= wd_wide[63:32];
          wr_q    <= req_write;
        end
        S_LO: if (hs) begin
          rd_lo_q <= bus_rdata;
          st_q    <= last_cyc ? S_IDLE : S_HI;
        end
        S_HI: if (hs) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_be)
      && $stable(bus_wdata) && $stable(bus_write)); // R6

  AST_SPLIT_NEXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !last_cyc |=> bus_valid && bus_addr == $past(bus_addr) + ADDR_W'(4)); // R3

  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_be != 4'b0000); // R4

  AST_LANE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HI) |-> int'($countones(bus_be)) + int'($countones(be_lo_q))
      == int'($countones(smask_q))); // R4

  AST_DONE_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(hs) && !$past(done)); // R8

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready); // R9

endmodule

// File: tb/ua_split_bench.sv
module ua_split_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_addr;
  logic [3:0]  bus_be;
  logic        bus_write;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        done;
  logic [31:0] done_rdata;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mem [64];

  always #4 clk = ~clk;

  ua_split #(.ADDR_W(32)) u_ua_split (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done(done), .done_rdata(done_rdata)
  );

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(logic [31:0] a, int n, int c);
    logic [29:0] w;
    logic [3:0]  m;
    w = a[31:2] + 30'(c);
    m = '0;
    for (int k = 0; k < n; k++) begin
      logic [31:0] b;
      b = a + 32'(k);
      if (b[31:2] == w) m[b[1:0]] = 1'b1;
    end
    return m;
  endfunction

  task automatic run(string tag, logic [31:0] a, logic [1:0] sz, bit wr,
                     logic [31:0] wd, int stall);
    int n, ncyc;
    logic [31:0] exp_rd;
    n    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    ncyc = (int'(a[1:0]) + n > 4) ? 2 : 1;
    exp_rd = '0;
    for (int k = 0; k < n; k++) begin
      logic [31:0] b;
      b = a + 32'(k);
      exp_rd[8*k +: 8] = mem[b[5:0]];
    end
    if (wr) exp_rd = '0;
    @(negedge clk);
    req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    for (int c = 0; c < ncyc; c++) begin
      logic [31:0] ea;
      logic [3:0]  eb;
      ea = {a[31:2] + 30'(c), 2'b00};
      eb = exp_be(a, n, c);
      @(negedge clk);
      check(bus_valid === 1'b1, "R3", {tag, " bus_valid"}, 64'(bus_valid), 64'd1);
      check(bus_addr === ea, c == 0 ? "R2" : "R10", {tag, " bus_addr"}, 64'(bus_addr), 64'(ea));
      check(bus_be === eb, c == 0 ? "R2" : "R4", {tag, " bus_be"}, 64'(bus_be), 64'(eb));
      check(bus_write === wr, "R5", {tag, " bus_write"}, 64'(bus_write), 64'(wr));
      check(req_ready === 1'b0, "R9", {tag, " req_ready busy"}, 64'(req_ready), 64'd0);
      if (wr) for (int j = 0; j < 4; j++) if (eb[j]) begin
        logic [31:0] k;
        k = ea + 32'(j) - a;
        check(bus_wdata[8*j +: 8] === wd[8*k +: 8], "R5", {tag, " write lane"},
              64'(bus_wdata[8*j +: 8]), 64'(wd[8*k +: 8]));
      end
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check(bus_valid === 1'b1 && bus_addr === ea && bus_be === eb, "R6",
              {tag, " stall hold"}, {bus_addr, 28'h0, bus_be}, {ea, 28'h0, eb});
        check(done === 1'b0, "R9", {tag, " no done while stalled"}, 64'(done), 64'd0);
      end
      for (int j = 0; j < 4; j++) begin
        logic [31:0] ba;
        ba = ea + 32'(j);
        bus_rdata[8*j +: 8] = eb[j] ? mem[ba[5:0]] : (8'hA5 ^ 8'(j));
        if (wr && eb[j]) mem[ba[5:0]] = bus_wdata[8*j +: 8];
      end
      bus_ready = 1'b1;
      @(posedge clk);
      #1 bus_ready = 1'b0;
      bus_rdata = 32'hDEAD_BEEF;
    end
    @(negedge clk);
    check(done === 1'b1, "R8", {tag, " done pulse"}, 64'(done), 64'd1);
    check(done_rdata === exp_rd, "R7", {tag, " result"}, 64'(done_rdata), 64'(exp_rd));
    check(bus_valid === 1'b0, "R3", {tag, " no extra cycle"}, 64'(bus_valid), 64'd0);
    req_valid = 1'b0;
    @(negedge clk);
    check(done === 1'b0, "R8", {tag, " done one cycle"}, 64'(done), 64'd0);
    check(bus_valid === 1'b0, "R9", {tag, " held request not re-accepted"}, 64'(bus_valid), 64'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready === 1'b1 && bus_valid === 1'b0 && done === 1'b0, "R1", "in reset",
          {req_ready, bus_valid, done}, 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && bus_valid === 1'b0 && done === 1'b0, "R1", "after reset",
          {req_ready, bus_valid, done}, 64'b100);
  endtask

  task automatic t_byte_reads();
    for (int o = 0; o < 4; o++) run("R2 byte read", 32'(8 + o), 2'd0, 1'b0, 32'h0, 0);
  endtask

  task automatic t_half_reads();
    run("R2 half aligned", 32'h10, 2'd1, 1'b0, 32'h0, 0);
    run("R2 half off1", 32'h11, 2'd1, 1'b0, 32'h0, 0);
    run("R3 half split", 32'h13, 2'd1, 1'b0, 32'h0, 1);
  endtask

  task automatic t_word_reads();
    for (int o = 0; o < 4; o++) run("R3 word read", 32'(16 + o), 2'd2, 1'b0, 32'h0, 0);
    run("R2 size3 word", 32'h21, 2'd3, 1'b0, 32'h0, 0);
  endtask

  task automatic t_writes();
    run("R5 word split write", 32'h26, 2'd2, 1'b1, 32'h4433_2211, 2);
    run("R7 readback", 32'h26, 2'd2, 1'b0, 32'h0, 0);
    run("R5 half split write", 32'h2B, 2'd1, 1'b1, 32'h0000_BBAA, 0);
    run("R7 readback half", 32'h2B, 2'd1, 1'b0, 32'h0, 0);
    run("R5 byte write", 32'h31, 2'd0, 1'b1, 32'hFFFF_FF5C, 0);
    run("R7 readback word", 32'h30, 2'd2, 1'b0, 32'h0, 0);
  endtask

  task automatic t_wrap();
    run("R10 top wrap", 32'hFFFF_FFFE, 2'd2, 1'b0, 32'h0, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
    repeat (2) @(posedge clk);
    t_reset();
    t_byte_reads();
    t_half_reads();
    t_word_reads();
    t_writes();
    t_wrap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog expired: actual hung expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule